// File: doc/BRIEF.md
# OTP Fuse Read Controller

This block lets a processor read rows of a one-time-programmable fuse array through a small register file on a single-cycle register port. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. The fuse contents come from an internal array whose contents are set by parameters. Each row holds 41 data bits and one stored check bit.

After reset, a load sequencer runs for a fixed number of cycles and then reports that the fuses are loaded. Software then does the following in order:
- sets the access-enable bit, and optionally the check-disable bit;
- writes a row number;
- raises the start bit with command code 0.

The controller captures the row and runs a read of fixed latency. It then places the row in two data registers and sets a sticky done flag, which software clears by writing 1 to it. It also raises an error flag when a protected row fails its parity check. Rows 0 to 15 are never flagged.

Top module: `otp_fuse_reader`

## Requirements
- R1: After reset every register reads as zero, including the load-done bit (offset 0x18, bit 3) and both flags in offset 0x1C.
- R2: The load-done bit rises exactly LOAD_CYCLES clock edges after reset is released and stays set. A start request made before it rises is ignored.
- R3: A write to offset 0x10 launches a read only when all of these hold: bit 0 goes from 0 to 1; bits 2:1, the command code, are 0; access enable (offset 0x00, bit 15) is set; fuse load is done; and no read is in flight. Any other write to 0x10 only updates the stored bits.
- R4: The done bit (offset 0x1C, bit 1) becomes set exactly READ_LAT clock edges after the edge that launched the read.
- R5: The done bit stays set until a write to 0x1C with bit 1 = 1. Writing 0 to that bit leaves it set.
- R6: Row r holds low word `(r*0x10003) ^ 0xA5A50000` and high part `r[8:0] ^ 0x0F3`. The low word reads at 0x20. The high part reads at bits 8:0 of 0x24, and bits 31:9 of 0x24 read as zero.
- R7: The stored check bit equals the XOR of the 41 data bits, inverted for rows where r mod 5 = 2. The error bit (0x1C, bit 17) is set at completion only when all of these hold: the check-disable bit (0x00, bit 9) was clear at launch, the row is above 15, and the check fails.
- R8: The error bit is cleared on the edge that launches the next read.
- R9: The row number is bits 15:6 of offset 0x0C and is captured at launch. Offset 0x00 reads back only bits 15 and 9, and 0x0C reads back only bits 15:6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |

## Verification
The hardest state to reach is a start request that arrives while its preconditions are false. The bench raises start during the fuse-load window and leaves it high. It then rewrites the bit as 1 again after loading finishes, and checks that neither write produces a done flag. The same approach covers a non-zero command code and a cleared access bit. A full sweep of all 1024 rows with checking enabled reaches the check-failure rows both below and above the protected boundary. A second sweep with checking disabled confirms that failing rows stay silent.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;
  localparam int BUS_AW = 6;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_CTRL  = 6'h00;
  localparam logic [BUS_AW-1:0] OFS_ROW   = 6'h0C;
  localparam logic [BUS_AW-1:0] OFS_CMD   = 6'h10;
  localparam logic [BUS_AW-1:0] OFS_STAT0 = 6'h18;
  localparam logic [BUS_AW-1:0] OFS_STAT1 = 6'h1C;
  localparam logic [BUS_AW-1:0] OFS_DLO   = 6'h20;
  localparam logic [BUS_AW-1:0] OFS_DHI   = 6'h24;

  localparam int BIT_ACC_EN   = 15;
  localparam int BIT_CHK_DIS  = 9;
  localparam int ROW_LSB      = 6;
  localparam int BIT_GO       = 0;
  localparam int OPC_LSB      = 1;
  localparam int OPC_W        = 2;
  localparam int BIT_LOADED   = 3;
  localparam int BIT_DONE     = 1;
  localparam int BIT_CHK_ERR  = 17;

  localparam logic [OPC_W-1:0] OPC_READ = '0;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int          ADDR_W    = 10,
  parameter int          DATA_W    = 41,
  parameter int          LO_W      = 32,
  parameter logic [31:0] LO_MULT   = 32'h0001_0003,
  parameter logic [31:0] LO_SEED   = 32'hA5A5_0000,
  parameter logic [31:0] HI_SEED   = 32'h0000_00F3,
  parameter int          FAULT_MOD = 5,
  parameter int          FAULT_REM = 2
) (
  input  logic [ADDR_W-1:0] row,
  output logic [DATA_W-1:0] data,
  output logic              chk
);
  localparam int HI_W = DATA_W - LO_W;

  logic [LO_W-1:0] lo_word;
  logic [HI_W-1:0] hi_word;
  logic            faulty;

  always_comb begin
    lo_word = LO_W'((32'(row) * LO_MULT) ^ LO_SEED);
    hi_word = HI_W'(32'(row) ^ HI_SEED);
    faulty  = ((32'(row) % FAULT_MOD) == FAULT_REM);
    data    = {hi_word, lo_word};
    chk     = (^data) ^ faulty;
  end
endmodule

// File: rtl/otp_load_seq.sv
module otp_load_seq #(
  parameter int LOAD_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic loaded
);
  localparam int CW = (LOAD_CYCLES > 1) ? $clog2(LOAD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOAD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      loaded <= 1'b0;
    end else if (!loaded) begin
      if (cnt == LAST) loaded <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  AST_LOADED_STAYS: assert property (@(posedge clk) disable iff (!rst_n) loaded |=> loaded); // R2
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq #(
  parameter int ADDR_W   = 10,
  parameter int READ_LAT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] row_in,
  input  logic              chk_dis_in,
  output logic              busy,
  output logic              fire,
  output logic [ADDR_W-1:0] row_q,
  output logic              chk_dis_q
);
  localparam int CW = (READ_LAT > 1) ? $clog2(READ_LAT) : 1;
  localparam logic [CW-1:0] FIRST = CW'(READ_LAT - 1);

  logic [CW-1:0] cnt;

  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      row_q     <= '0;
      chk_dis_q <= 1'b0;
    end else if (launch && !busy) begin
      busy      <= 1'b1;
      cnt       <= FIRST;
      row_q     <= row_in;
      chk_dis_q <= chk_dis_in;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy && !fire |=> $stable(row_q)); // R9
  AST_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n) fire |=> !fire); // R4
endmodule

// File: rtl/otp_fuse_reader.sv
module otp_fuse_reader
  import otp_rd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 41,
  parameter int LO_W        = 32,
  parameter int UNPROT_ROWS = 16,
  parameter int LOAD_CYCLES = 64,
  parameter int READ_LAT    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata
);
  localparam int HI_W = DATA_W - LO_W;

  logic              acc_en, chk_dis;
  logic [ADDR_W-1:0] row_reg;
  logic              go_q;
  logic [OPC_W-1:0]  opc_q;
  logic              done_q, err_q;
  logic [LO_W-1:0]   dlo_q;
  logic [HI_W-1:0]   dhi_q;

  logic              loaded, busy, fire, chk_dis_q, chk_bit;
  logic [ADDR_W-1:0] row_q;
  logic [DATA_W-1:0] fuse_data;
  logic              wr_cmd, wr_stat1, launch;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
  assign wr_stat1 = bus_wr && (bus_addr == OFS_STAT1);
  assign launch   = wr_cmd && bus_wdata[BIT_GO] && !go_q &&
                    (bus_wdata[OPC_LSB +: OPC_W] == OPC_READ) &&
                    acc_en && loaded && !busy;

  otp_load_seq #(.LOAD_CYCLES(LOAD_CYCLES)) u_load (
    .clk(clk), .rst_n(rst_n), .loaded(loaded)
  );

  otp_read_seq #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .row_in(row_reg),
    .chk_dis_in(chk_dis), .busy(busy), .fire(fire), .row_q(row_q),
    .chk_dis_q(chk_dis_q)
  );

  otp_fuse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)) u_array (
    .row(row_q), .data(fuse_data), .chk(chk_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_en  <= 1'b0;
      chk_dis <= 1'b0;
      row_reg <= '0;
      go_q    <= 1'b0;
      opc_q   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_CTRL) begin
        acc_en  <= bus_wdata[BIT_ACC_EN];
        chk_dis <= bus_wdata[BIT_CHK_DIS];
      end
      if (bus_addr == OFS_ROW) row_reg <= bus_wdata[ROW_LSB +: ADDR_W];
      if (bus_addr == OFS_CMD) begin
        go_q  <= bus_wdata[BIT_GO];
        opc_q <= bus_wdata[OPC_LSB +: OPC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dlo_q  <= '0;
      dhi_q  <= '0;
    end else begin
      if (launch) err_q <= 1'b0;
      if (fire) begin
        done_q <= 1'b1;
        dlo_q  <= fuse_data[LO_W-1:0];
        dhi_q  <= fuse_data[DATA_W-1:LO_W];
        err_q  <= !chk_dis_q && (32'(row_q) >= UNPROT_ROWS) &&
                  ((^fuse_data) != chk_bit);
      end else if (wr_stat1 && bus_wdata[BIT_DONE]) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[BIT_ACC_EN]  = acc_en;
        bus_rdata[BIT_CHK_DIS] = chk_dis;
      end
      OFS_ROW:   bus_rdata[ROW_LSB +: ADDR_W] = row_reg;
      OFS_CMD: begin
        bus_rdata[BIT_GO]            = go_q;
        bus_rdata[OPC_LSB +: OPC_W]  = opc_q;
      end
      OFS_STAT0: bus_rdata[BIT_LOADED] = loaded;
      OFS_STAT1: begin
        bus_rdata[BIT_DONE]    = done_q;
        bus_rdata[BIT_CHK_ERR] = err_q;
      end
      OFS_DLO:   bus_rdata[LO_W-1:0] = dlo_q;
      OFS_DHI:   bus_rdata[HI_W-1:0] = dhi_q;
      default:   bus_rdata = '0;
    endcase
  end

  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> loaded); // R2
  AST_DONE_FROM_SEQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> $past(busy)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done_q && !(wr_stat1 && bus_wdata[BIT_DONE]) |=> done_q); // R5
  AST_ERR_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_q) |-> (32'(row_q) >= UNPROT_ROWS) && !chk_dis_q); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) launch |=> !err_q); // R8
  AST_NO_LAUNCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) !acc_en || !loaded |=> !$rose(busy)); // R3
endmodule

// File: tb/otp_fuse_reader_tb.sv
module otp_fuse_reader_tb;
  localparam int LOAD = 64;
  localparam int LAT  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  int since_rel = 0;
  int cyc = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  otp_fuse_reader u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) since_rel <= since_rel + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_lo(input int r);
    return (32'(r) * 32'h0001_0003) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] exp_hi(input int r);
    return {23'b0, 9'(r) ^ 9'h0F3};
  endfunction

  task automatic do_read(input int r, input bit cdis, input string req);
    int n;
    logic [31:0] s;
    wr(6'h00, 32'h8000 | (cdis ? 32'h200 : 32'h0));
    wr(6'h0C, 32'(r) << 6);
    wr(6'h10, 32'h1);
    n = 0;
    do begin
      @(negedge clk); n++;
      rd(6'h1C, s);
    end while (!s[1] && n < 40);
    chk({req, " R4 latency"}, n, LAT);
    wr(6'h10, 32'h0);
    rd(6'h20, s); chk({req, " R6 low"}, s, exp_lo(r));
    rd(6'h24, s); chk({req, " R6 high"}, s, exp_hi(r));
    rd(6'h1C, s);
    chk({req, " R7 err"}, {31'b0, s[17]},
        {31'b0, (!cdis && r > 15 && (r % 5) == 2)});
    wr(6'h1C, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd(6'h00, rv); chk("R1 ctrl", rv, 0);
    rd(6'h18, rv); chk("R1 stat0", rv, 0);
    rd(6'h1C, rv); chk("R1 stat1", rv, 0);
    rd(6'h24, rv); chk("R1 dhi", rv, 0);
    rst_n = 1'b1;
    // R2: start attempted during load must be ignored
    wr(6'h00, 32'h8000);
    wr(6'h10, 32'h1);
    while (1) begin
      rd(6'h18, rv);
      if (rv[3] || since_rel > 200) break;
      @(negedge clk);
    end
    chk("R2 load time", since_rel, LOAD);
    repeat (LAT + 2) @(negedge clk);
    rd(6'h1C, rv); chk("R2 early start ignored", rv, 0);
    // R3: start held high, no rising edge
    wr(6'h10, 32'h1);
    repeat (LAT + 2) @(negedge clk);
    rd(6'h1C, rv); chk("R3 no rise", rv, 0);
    wr(6'h10, 32'h0);
    // R3: nonzero command code
    wr(6'h10, 32'h3);
    repeat (LAT + 2) @(negedge clk);
    rd(6'h1C, rv); chk("R3 opcode", rv, 0);
    rd(6'h10, rv); chk("R3 cmd readback", rv, 3);
    wr(6'h10, 32'h0);
    // R3: access disabled
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h1);
    repeat (LAT + 2) @(negedge clk);
    rd(6'h1C, rv); chk("R3 no access", rv, 0);
    wr(6'h10, 32'h0);
    // R9 readback masks
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, rv); chk("R9 ctrl mask", rv, 32'h0000_8200);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, rv); chk("R9 row mask", rv, 32'h0000_FFC0);
    // R4 exact latency and R5 stickiness
    wr(6'h00, 32'h8000);
    wr(6'h0C, 32'(37) << 6);
    wr(6'h10, 32'h1);
    repeat (LAT - 1) @(negedge clk);
    rd(6'h1C, rv); chk("R4 not yet", {31'b0, rv[1]}, 0);
    wr(6'h0C, 32'(5) << 6);   // R9: change after launch has no effect
    rd(6'h1C, rv); chk("R4 done", {31'b0, rv[1]}, 1);
    rd(6'h20, rv); chk("R9 captured row", rv, exp_lo(37));
    rd(6'h1C, rv); chk("R7 row 37 err", {31'b0, rv[17]}, 1);
    wr(6'h1C, 32'h0);
    rd(6'h1C, rv); chk("R5 write 0 keeps", {31'b0, rv[1]}, 1);
    wr(6'h10, 32'h0);
    wr(6'h0C, 32'(40) << 6);
    wr(6'h10, 32'h1);          // R8: launch clears error
    rd(6'h1C, rv); chk("R8 err cleared", {31'b0, rv[17]}, 0);
    repeat (LAT) @(negedge clk);
    wr(6'h1C, 32'h2);
    rd(6'h1C, rv); chk("R5 w1c", {31'b0, rv[1]}, 0);
    wr(6'h10, 32'h0);
    // Sweep: all rows with checking on, low rows with checking off
    for (int r = 0; r < 1024; r++) do_read(r, 1'b0, "sweep");
    for (int r = 0; r < 64; r++) do_read(r, 1'b1, "nochk");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule